// File: doc/BRIEF.md
# Four-Channel Lockstep Serial Converter Capture

This block is a serial-bus master that reads four synchronized analog-to-digital converters at once. One serial clock, one conversion-start strobe and one command line are shared by all four converters. Each converter returns its result on its own input line, and the block samples all four lines on the same clock edge. Each acquisition cycle has three steps. The block pulses the conversion-start strobe, waits a programmable number of system cycles for the conversion, and then runs one chip-select frame. During that frame a fixed command word shifts out on the shared line while one sample is shifted in from every converter.

The four samples of a frame are packed into one entry, with channel 0 in the least significant slice. Entries are written into two circular buffers that take turns. When the active buffer holds the configured number of entries, writes move to the other buffer. At the same time a one-cycle ready pulse names the buffer that just filled. A consumer reads the filled buffer through a combinational read port and acknowledges it. If a buffer switch happens while the previous ready is still unacknowledged, a sticky overrun flag is set. A level-sensitive run input starts continuous acquisition at a programmable frame period. Dropping the run input stops acquisition only after the frame in progress has finished.

Top module: `quad_adc_capture`

## Requirements
- R1: While reset is held and right after it is released: `cs_n_o`=1, `sclk_o`=0, `cnvst_o`=0, `mosi_o`=0, `ready_o`=0 and `overrun_o`=0.
- R2: Each acquisition begins with `cnvst_o` high for exactly one system cycle, with `cs_n_o` high during that cycle. `cs_n_o` falls exactly `conv_wait_i`+2 system cycles after the cycle in which `cnvst_o` rises.
- R3: A frame keeps `cs_n_o` low for exactly 2·SAMPLE_W system cycles. During the frame, `sclk_o` has a period of two system cycles and exactly SAMPLE_W rising edges. `sclk_o` is low whenever `cs_n_o` is high.
- R4: `mosi_o` carries `cmd_word_i` most significant bit first. The first bit is valid when `cs_n_o` falls, and `mosi_o` changes only in the cycle where `sclk_o` falls, never where it rises.
- R5: Each line `miso_i[c]` is sampled on each rising edge of `sclk_o`, most significant bit first, with all four lines in lockstep. Channel c's sample is stored in bits [c·SAMPLE_W +: SAMPLE_W] of the entry.
- R6: Entries go to consecutive addresses starting at 0 in the active buffer. Buffer 0 is active after reset. `rd_data_o` combinationally returns the entry at (`rd_buf_i`, `rd_addr_i`).
- R7: When the entry that brings the active buffer to its length is written, writes move to the other buffer at address 0. In the next cycle `ready_o` is high for one cycle and `ready_buf_o` names the buffer that filled. A `buf_len_i` of 0, or one above BUF_DEPTH, means BUF_DEPTH.
- R8: `ack_i` clears the pending ready. A buffer switch while a ready is still pending sets `overrun_o`, which stays set until `ovr_clr_i` is asserted.
- R9: While `run_i` stays high, successive rising edges of `cnvst_o` are max(`frame_period_i`, 2·SAMPLE_W+`conv_wait_i`+3) system cycles apart.
- R10: Deasserting `run_i` during an acquisition lets that frame complete and write its entry. No further `cnvst_o` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Continuous acquisition enable (level) |
| conv_wait_i | input | CNT_W | Conversion wait in system cycles |
| frame_period_i | input | CNT_W | Minimum spacing of conversion starts |
| cmd_word_i | input | SAMPLE_W | Command word shifted out each frame |
| buf_len_i | input | clog2(BUF_DEPTH+1) | Entries per buffer (0 = BUF_DEPTH) |
| cnvst_o | output | 1 | Shared conversion-start strobe |
| cs_n_o | output | 1 | Shared chip select, active low |
| sclk_o | output | 1 | Shared serial clock, idles low |
| mosi_o | output | 1 | Shared command data line |
| miso_i | input | N_CH | Per-converter data return lines |
| ready_o | output | 1 | One-cycle buffer-full pulse |
| ready_buf_o | output | 1 | Index of the buffer that filled |
| ack_i | input | 1 | Consumer acknowledge of ready |
| overrun_o | output | 1 | Sticky overrun flag |
| ovr_clr_i | input | 1 | Clears the overrun flag |
| rd_buf_i | input | 1 | Read port buffer select |
| rd_addr_i | input | clog2(BUF_DEPTH) | Read port entry address |
| rd_data_o | output | N_CH*SAMPLE_W | Packed four-channel entry |

## Verification
Each converter model returns a different value in every frame, so a design that swaps lanes, reverses the channel packing or samples on the falling edge would store words that do not match the scoreboard. The bench uses three buffer lengths: one that wraps after three entries, a zero length that must mean full depth, and length one. The length-one case exposes a design that counts to the wrong address or reports the wrong buffer index. It also runs back-to-back switches with acknowledge withheld, so a design that never sets overrun, or lets overrun clear on its own, would be caught. The bench drops run just after a conversion start, which catches a design that aborts the frame in progress or issues one extra start. It measures both the minimum-spacing case and the programmed-period case, which catches an off-by-one in the wait or period counters.

// File: rtl/qac_pkg.sv
`timescale 1ns/1ps
package qac_pkg;

    // Acquisition sequencer phases.
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for run
        ST_CONV,   // conversion-start strobe high
        ST_WAIT,   // conversion time
        ST_SHIFT,  // chip select low, bits moving
        ST_GAP     // frame done, holding for the period
    } seq_state_e;

endpackage

// File: rtl/qac_seq.sv
`timescale 1ns/1ps
// Conversion-start, wait and frame timing for the shared serial lines.
module qac_seq
    import qac_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int CNT_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic [CNT_W-1:0]    conv_wait_i,
    input  logic [CNT_W-1:0]    frame_period_i,
    input  logic [SAMPLE_W-1:0] cmd_word_i,
    output logic                cnvst_o,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                mosi_o,
    output logic                cap_o,
    output logic                done_o
);

    localparam int             BW      = $clog2(SAMPLE_W);
    localparam logic [BW-1:0]  LAST_BIT = BW'(SAMPLE_W - 1);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    typedef struct packed {
        seq_state_e          st;
        logic                cnvst;
        logic                cs_n;
        logic                sclk;
        logic [SAMPLE_W-1:0] tx;
        logic [BW-1:0]       bitc;
        logic [CNT_W-1:0]    wcnt;
        logic [CNT_W-1:0]    per;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_IDLE, cnvst: 1'b0, cs_n: 1'b1, sclk: 1'b0,
                                 tx: '0, bitc: '0, wcnt: '0, per: '0};

    seq_t seq_d, seq_q;
    logic period_met;

    assign period_met = ({1'b0, seq_q.per} + (CNT_W+1)'(1)) >= {1'b0, frame_period_i};

    always_comb begin
        seq_d       = seq_q;
        seq_d.cnvst = 1'b0;
        if (seq_q.st != ST_IDLE && seq_q.per != {CNT_W{1'b1}}) begin
            seq_d.per = seq_q.per + ONE_C;
        end
        case (seq_q.st)
            ST_IDLE: begin
                if (run_i) begin
                    seq_d.st    = ST_CONV;
                    seq_d.cnvst = 1'b1;
                    seq_d.per   = '0;
                end
            end
            ST_CONV: begin
                seq_d.st   = ST_WAIT;
                seq_d.wcnt = '0;
            end
            ST_WAIT: begin
                if (seq_q.wcnt == conv_wait_i) begin
                    seq_d.st   = ST_SHIFT;
                    seq_d.cs_n = 1'b0;
                    seq_d.sclk = 1'b0;
                    seq_d.tx   = cmd_word_i;
                    seq_d.bitc = '0;
                end else begin
                    seq_d.wcnt = seq_q.wcnt + ONE_C;
                end
            end
            ST_SHIFT: begin
                if (!seq_q.sclk) begin
                    seq_d.sclk = 1'b1;
                end else begin
                    seq_d.sclk = 1'b0;
                    if (seq_q.bitc == LAST_BIT) begin
                        seq_d.cs_n = 1'b1;
                        seq_d.tx   = '0;
                        seq_d.st   = ST_GAP;
                    end else begin
                        seq_d.tx   = {seq_q.tx[SAMPLE_W-2:0], 1'b0};
                        seq_d.bitc = seq_q.bitc + BW'(1);
                    end
                end
            end
            ST_GAP: begin
                if (!run_i) begin
                    seq_d.st = ST_IDLE;
                end else if (period_met) begin
                    seq_d.st    = ST_CONV;
                    seq_d.cnvst = 1'b1;
                    seq_d.per   = '0;
                end
            end
            default: seq_d = SEQ_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= SEQ_RST;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cnvst_o = seq_q.cnvst;
    assign cs_n_o  = seq_q.cs_n;
    assign sclk_o  = seq_q.sclk;
    assign mosi_o  = seq_q.tx[SAMPLE_W-1];
    assign cap_o   = (seq_q.st == ST_SHIFT) && !seq_q.sclk;
    assign done_o  = (seq_q.st == ST_SHIFT) && seq_q.sclk && (seq_q.bitc == LAST_BIT);

endmodule

// File: rtl/qac_deser.sv
`timescale 1ns/1ps
// Per-channel shift registers, all advanced by one capture strobe.
module qac_deser #(
    parameter int N_CH     = 4,
    parameter int SAMPLE_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cap_i,
    input  logic [N_CH-1:0]            miso_i,
    output logic [N_CH*SAMPLE_W-1:0]   word_o
);

    for (genvar c = 0; c < N_CH; c++) begin : g_lane
        logic [SAMPLE_W-1:0] sh_d, sh_q;

        always_comb begin
            sh_d = sh_q;
            if (cap_i) begin
                sh_d = {sh_q[SAMPLE_W-2:0], miso_i[c]};
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh_q <= '0;
            end else begin
                sh_q <= sh_d;
            end
        end

        assign word_o[c*SAMPLE_W +: SAMPLE_W] = sh_q;
    end

endmodule

// File: rtl/qac_pingpong.sv
`timescale 1ns/1ps
// Two alternating circular buffers with ready and overrun tracking.
module qac_pingpong #(
    parameter int N_CH      = 4,
    parameter int SAMPLE_W  = 16,
    parameter int BUF_DEPTH = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 we_i,
    input  logic [N_CH*SAMPLE_W-1:0]             wdata_i,
    input  logic [$clog2(BUF_DEPTH+1)-1:0]       buf_len_i,
    input  logic                                 ack_i,
    input  logic                                 ovr_clr_i,
    input  logic                                 rd_buf_i,
    input  logic [$clog2(BUF_DEPTH)-1:0]         rd_addr_i,
    output logic [N_CH*SAMPLE_W-1:0]             rd_data_o,
    output logic                                 ready_o,
    output logic                                 ready_buf_o,
    output logic                                 overrun_o
);

    localparam int AW = $clog2(BUF_DEPTH);
    localparam int LW = $clog2(BUF_DEPTH + 1);
    localparam int EW = N_CH * SAMPLE_W;
    localparam logic [LW-1:0] FULL_LEN = LW'(BUF_DEPTH);

    typedef struct packed {
        logic          sel;
        logic [AW-1:0] wptr;
        logic          ready;
        logic          rbuf;
        logic          pend;
        logic          ovr;
    } pp_t;

    pp_t pp_d, pp_q;
    logic [EW-1:0] mem_q [2][BUF_DEPTH];
    logic [LW-1:0] eff_len;
    logic [LW-1:0] fill;
    logic          wrap;

    assign eff_len = (buf_len_i == '0 || buf_len_i > FULL_LEN) ? FULL_LEN : buf_len_i;
    assign fill    = LW'(pp_q.wptr) + LW'(1);
    assign wrap    = we_i && (fill >= eff_len);

    always_comb begin
        pp_d       = pp_q;
        pp_d.ready = 1'b0;
        pp_d.pend  = pp_q.pend & ~ack_i;
        pp_d.ovr   = pp_q.ovr & ~ovr_clr_i;
        if (we_i) begin
            if (wrap) begin
                pp_d.wptr  = '0;
                pp_d.sel   = ~pp_q.sel;
                pp_d.ready = 1'b1;
                pp_d.rbuf  = pp_q.sel;
                pp_d.pend  = 1'b1;
                if (pp_q.pend && !ack_i) begin
                    pp_d.ovr = 1'b1;
                end
            end else begin
                pp_d.wptr = pp_q.wptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pp_q <= '0;
        end else begin
            pp_q <= pp_d;
        end
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[pp_q.sel][pp_q.wptr] <= wdata_i;
        end
    end

    assign rd_data_o   = mem_q[rd_buf_i][rd_addr_i];
    assign ready_o     = pp_q.ready;
    assign ready_buf_o = pp_q.rbuf;
    assign overrun_o   = pp_q.ovr;

endmodule

// File: rtl/quad_adc_capture.sv
`timescale 1ns/1ps
// Top: shared-clock serial master capturing four converters into ping-pong buffers.
module quad_adc_capture #(
    parameter int SAMPLE_W  = 16,
    parameter int N_CH      = 4,
    parameter int BUF_DEPTH = 8,
    parameter int CNT_W     = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               run_i,
    input  logic [CNT_W-1:0]                   conv_wait_i,
    input  logic [CNT_W-1:0]                   frame_period_i,
    input  logic [SAMPLE_W-1:0]                cmd_word_i,
    input  logic [$clog2(BUF_DEPTH+1)-1:0]     buf_len_i,
    output logic                               cnvst_o,
    output logic                               cs_n_o,
    output logic                               sclk_o,
    output logic                               mosi_o,
    input  logic [N_CH-1:0]                    miso_i,
    output logic                               ready_o,
    output logic                               ready_buf_o,
    input  logic                               ack_i,
    output logic                               overrun_o,
    input  logic                               ovr_clr_i,
    input  logic                               rd_buf_i,
    input  logic [$clog2(BUF_DEPTH)-1:0]       rd_addr_i,
    output logic [N_CH*SAMPLE_W-1:0]           rd_data_o
);

    logic                       cap;
    logic                       done;
    logic [N_CH*SAMPLE_W-1:0]   word;

    qac_seq #(
        .SAMPLE_W (SAMPLE_W),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .run_i          (run_i),
        .conv_wait_i    (conv_wait_i),
        .frame_period_i (frame_period_i),
        .cmd_word_i     (cmd_word_i),
        .cnvst_o        (cnvst_o),
        .cs_n_o         (cs_n_o),
        .sclk_o         (sclk_o),
        .mosi_o         (mosi_o),
        .cap_o          (cap),
        .done_o         (done)
    );

    qac_deser #(
        .N_CH     (N_CH),
        .SAMPLE_W (SAMPLE_W)
    ) u_deser (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .miso_i (miso_i),
        .word_o (word)
    );

    qac_pingpong #(
        .N_CH      (N_CH),
        .SAMPLE_W  (SAMPLE_W),
        .BUF_DEPTH (BUF_DEPTH)
    ) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (done),
        .wdata_i     (word),
        .buf_len_i   (buf_len_i),
        .ack_i       (ack_i),
        .ovr_clr_i   (ovr_clr_i),
        .rd_buf_i    (rd_buf_i),
        .rd_addr_i   (rd_addr_i),
        .rd_data_o   (rd_data_o),
        .ready_o     (ready_o),
        .ready_buf_o (ready_buf_o),
        .overrun_o   (overrun_o)
    );

endmodule

// File: rtl/qac_checker.sv
`timescale 1ns/1ps
// Temporal properties of the capture block's port behaviour.
module qac_checker (
    input logic clk,
    input logic rst_n,
    input logic cnvst_o,
    input logic cs_n_o,
    input logic sclk_o,
    input logic mosi_o,
    input logic ready_o,
    input logic overrun_o,
    input logic ovr_clr_i
);

    p_cnvst_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_o |=> !cnvst_o);

    p_cnvst_outside_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnvst_o |-> cs_n_o);

    p_sclk_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);

    p_mosi_holds_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && $rose(sclk_o)) |-> $stable(mosi_o));

    p_ready_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun_o && !ovr_clr_i) |=> overrun_o);

endmodule

bind quad_adc_capture qac_checker u_qac_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnvst_o   (cnvst_o),
    .cs_n_o    (cs_n_o),
    .sclk_o    (sclk_o),
    .mosi_o    (mosi_o),
    .ready_o   (ready_o),
    .overrun_o (overrun_o),
    .ovr_clr_i (ovr_clr_i)
);

// File: tb/quad_adc_capture_test.sv
`timescale 1ns/1ps
module quad_adc_capture_test;

    localparam int W     = 16;
    localparam int NCH   = 4;
    localparam int DEPTH = 8;
    localparam int CW    = 16;
    localparam int AW    = $clog2(DEPTH);
    localparam int LW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run = 1'b0;
    logic [CW-1:0] conv_wait = '0;
    logic [CW-1:0] frame_period = '0;
    logic [W-1:0]  cmd = '0;
    logic [LW-1:0] buf_len = '0;
    logic cnvst, cs_n, sclk, mosi;
    logic [NCH-1:0] miso;
    logic ready, ready_buf, overrun;
    logic ack = 1'b0;
    logic ovr_clr = 1'b0;
    logic rd_buf = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [NCH*W-1:0] rd_data;

    quad_adc_capture #(
        .SAMPLE_W (W), .N_CH (NCH), .BUF_DEPTH (DEPTH), .CNT_W (CW)
    ) uut (
        .clk (clk), .rst_n (rst_n), .run_i (run), .conv_wait_i (conv_wait),
        .frame_period_i (frame_period), .cmd_word_i (cmd), .buf_len_i (buf_len),
        .cnvst_o (cnvst), .cs_n_o (cs_n), .sclk_o (sclk), .mosi_o (mosi),
        .miso_i (miso), .ready_o (ready), .ready_buf_o (ready_buf), .ack_i (ack),
        .overrun_o (overrun), .ovr_clr_i (ovr_clr), .rd_buf_i (rd_buf),
        .rd_addr_i (rd_addr), .rd_data_o (rd_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] smp(input int f, input int ch);
        int v;
        v = ((f + 1) * 40503) + ((ch + 1) * 499) + (ch << 12);
        return W'(v);
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Converter models and expected-entry driver.
    logic [NCH-1:0][W-1:0] sv = '0;
    logic [NCH*W-1:0] exp_q[$];
    int   frame_no = 0;
    int   nrise = 0;
    logic [W-1:0] rx_cmd = '0;
    bit   in_frame = 1'b0;

    always_comb begin
        for (int c = 0; c < NCH; c++) miso[c] = sv[c][W-1];
    end

    task automatic load_frame();
        logic [NCH*W-1:0] e;
        for (int c = 0; c < NCH; c++) begin
            sv[c] = smp(frame_no, c);
            e[c*W +: W] = smp(frame_no, c);
        end
        exp_q.push_back(e);
        frame_no++;
    endtask

    always @(negedge cs_n) begin
        load_frame();
        nrise = 0;
        rx_cmd = '0;
        in_frame = 1'b1;
    end

    always @(negedge sclk) begin
        if (!cs_n) begin
            for (int c = 0; c < NCH; c++) sv[c] = {sv[c][W-2:0], 1'b0};
        end
    end

    always @(posedge sclk) begin
        if (!cs_n) begin
            rx_cmd = {rx_cmd[W-2:0], mosi};
            nrise++;
        end
    end

    always @(posedge cs_n) begin
        if (in_frame) begin
            in_frame = 1'b0;
            chk(nrise == W, "R3 sclk rising edges per frame", 64'(nrise), 64'(W));
            chk(rx_cmd == cmd, "R4 command bits on mosi", 64'(rx_cmd), 64'(cmd));
        end
    end

    // Timing monitor for conversion start and chip select.
    int t_cnv[$];
    int cs_t = 0;
    logic cnv_prev = 1'b0;
    logic cs_prev  = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cnvst && !cnv_prev) t_cnv.push_back(cyc);
            if (!cs_n && cs_prev && t_cnv.size() > 0) begin
                chk(cyc - t_cnv[$] == int'(conv_wait) + 2, "R2 cs fall after cnvst",
                    64'(cyc - t_cnv[$]), 64'(int'(conv_wait) + 2));
                cs_t = cyc;
            end
            if (cs_n && !cs_prev) begin
                chk(cyc - cs_t == 2 * W, "R3 cs low length", 64'(cyc - cs_t), 64'(2 * W));
            end
            cnv_prev = cnvst;
            cs_prev  = cs_n;
        end
    end

    // Scoreboard monitor: drains a filled buffer and compares with the queue.
    bit ack_en  = 1'b1;
    bit exp_buf = 1'b0;
    int eff_len = DEPTH;
    int n_ready = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ready) begin
                n_ready++;
                chk(ready_buf == exp_buf, "R7 ready names filled buffer",
                    64'(ready_buf), 64'(exp_buf));
                rd_buf = ready_buf;
                for (int a = 0; a < eff_len; a++) begin
                    logic [NCH*W-1:0] e;
                    rd_addr = AW'(a);
                    #0.5;
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R6 unexpected entry", 64'(rd_data), 64'(0));
                    end else begin
                        e = exp_q.pop_front();
                        chk(rd_data == e, "R5 R6 packed entry contents", 64'(rd_data), 64'(e));
                    end
                end
                exp_buf = ~exp_buf;
                ack = ack_en;
                @(negedge clk);
                chk(ready == 1'b0, "R7 ready lasts one cycle", 64'(ready), 64'(0));
                ack = 1'b0;
            end
        end
    end

    task automatic run_frames(input int upto);
        run = 1'b1;
        while (t_cnv.size() < upto) @(negedge clk);
        run = 1'b0;
        repeat (200) @(negedge clk);
        chk(t_cnv.size() == upto, "R10 no start after run drops",
            64'(t_cnv.size()), 64'(upto));
        chk(frame_no == upto, "R10 started frame completes", 64'(frame_no), 64'(upto));
    endtask

    task automatic check_period(input int first, input int last, input int per);
        for (int i = first + 1; i < last; i++) begin
            chk(t_cnv[i] - t_cnv[i-1] == per, "R9 conversion start spacing",
                64'(t_cnv[i] - t_cnv[i-1]), 64'(per));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && sclk == 1'b0, "R1 lines idle in reset", {cs_n, sclk}, 2'b10);
        chk(cnvst == 1'b0 && mosi == 1'b0, "R1 strobe and data low in reset", {cnvst, mosi}, 0);
        chk(ready == 1'b0 && overrun == 1'b0, "R1 flags clear in reset", {ready, overrun}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1 && cnvst == 1'b0, "R1 idle after reset", {cs_n, cnvst}, 2'b10);

        // Minimum spacing, three-entry buffers, acknowledged.
        conv_wait = 16'd5; frame_period = 16'd0; cmd = 16'hC3A5;
        buf_len = LW'(3); eff_len = 3; ack_en = 1'b1;
        run_frames(6);
        check_period(0, 6, 2 * W + 5 + 3);
        chk(n_ready == 2, "R7 two buffers filled", 64'(n_ready), 64'(2));
        chk(overrun == 1'b0, "R8 no overrun when acknowledged", 64'(overrun), 64'(0));
        chk(exp_q.size() == 0, "R6 all entries drained", 64'(exp_q.size()), 64'(0));

        // Programmed period, zero length means full depth.
        conv_wait = 16'd0; frame_period = 16'd60; cmd = 16'h5A0F;
        buf_len = '0; eff_len = DEPTH;
        run_frames(14);
        check_period(6, 14, 60);
        chk(n_ready == 3, "R7 zero length fills full depth", 64'(n_ready), 64'(3));
        chk(exp_q.size() == 0, "R6 all entries drained", 64'(exp_q.size()), 64'(0));

        // Single-entry buffers with acknowledge withheld.
        conv_wait = 16'd2; frame_period = 16'd0; cmd = 16'h8001;
        buf_len = LW'(1); eff_len = 1; ack_en = 1'b0;
        run_frames(17);
        chk(n_ready == 6, "R7 every entry switches buffer", 64'(n_ready), 64'(6));
        chk(overrun == 1'b1, "R8 overrun on unacknowledged switch", 64'(overrun), 64'(1));
        repeat (10) @(negedge clk);
        chk(overrun == 1'b1, "R8 overrun stays set", 64'(overrun), 64'(1));
        ovr_clr = 1'b1;
        @(negedge clk);
        ovr_clr = 1'b0;
        @(negedge clk);
        chk(overrun == 1'b0, "R8 overrun cleared", 64'(overrun), 64'(0));

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

endmodule